// File: doc/BRIEF.md
# Channel Status Flag Extractor with Block Start

This block sits behind a digital audio interface decoder and follows the 192-frame channel status block. For every decoded subframe it is given the status bit, the user bit, a channel indication, a mark for a block-start preamble and a one-cycle strobe. It sends the status and user bits out again as two serial streams, one bit per subframe. Left and right alternate on these streams.

A frame counter locks to the block-start preamble. From that count the block produces a window output that is high for the first 32 frames of each block. It also gathers the first status byte from the left channel only and decodes three flags from it:
- professional versus consumer format,
- pre-emphasis, read from a field whose position depends on the format,
- audio versus non-audio content.

A block that runs past 192 frames without a new preamble sets a sticky error bit.

Top module: `cs_flag_extract`

## Requirements
- R1: On a clock edge where `sub_stb` is high, `cs_ser` and `ub_ser` take `cs_in` and `ub_in`, visible one cycle later. They keep that value until the next strobe.
- R2: A left subframe (`sub_right`=0) strobed with `b_pre`=1 is frame 0. Each later left subframe increments the frame number. A right subframe belongs to the frame of the preceding left one. A preamble in the middle of a block restarts the count at 0. Left subframes strobed before the first preamble after reset are not counted: the window and flags stay low.
- R3: `blk_win` goes high at the left subframe of frame 0. It stays high through frame 31 and is low for frames 32 to 191.
- R4: Status byte 0 is built from the left subframes of frames 0 to 7, with bit n taken from frame n. Status bits of right subframes never affect the flags.
- R5: `pro_mode` equals byte 0 bit 0 (1 = professional, 0 = consumer).
- R6: In professional mode, `emph_flag` is 1 only when bit 2 = 1, bit 3 = 1 and bit 4 = 0.
- R7: In consumer mode, `emph_flag` is 1 only when bit 3 = 1, bit 4 = 0 and bit 5 = 0. Bit 2 is not looked at.
- R8: `nonaudio_flag` equals byte 0 bit 1 (0 = PCM audio, 1 = non-audio data).
- R9: The three flags change only on the left subframe of frame 7. At all other times they hold their value.
- R10: A left subframe that arrives after frame 191 without a preamble wraps to frame 0 and sets `sync_err`. The wrapped frame then behaves as frame 0 in every other respect. `sync_err` stays set until reset.
- R11: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_stb | input | 1 | One-cycle strobe per decoded subframe |
| sub_right | input | 1 | Channel of the strobed subframe: 0 left, 1 right |
| b_pre | input | 1 | The strobed subframe carries a block-start preamble |
| cs_in | input | 1 | Channel status bit of the strobed subframe |
| ub_in | input | 1 | User bit of the strobed subframe |
| cs_ser | output | 1 | Serial channel status stream |
| ub_ser | output | 1 | Serial user bit stream |
| blk_win | output | 1 | High for frames 0 to 31 of each block |
| pro_mode | output | 1 | Byte 0 indicates professional format |
| emph_flag | output | 1 | 50/15 us pre-emphasis indicated |
| nonaudio_flag | output | 1 | Stream carries non-audio data |
| sync_err | output | 1 | Sticky: block overran 192 frames without a preamble |

## Verification
The main decode is exercised with eight byte-0 patterns.
- Consumer bytes with the emphasis field set, with bit 2 set and with bit 4 set separate the consumer field from the professional one.
- Professional bytes that fail on bit 2 or on bit 4 separate the professional field from the consumer one.
- Bytes with bit 1 set isolate the non-audio flag.

The right channel always carries the complement of the left byte, so any leakage from the right channel flips a flag. Frame-boundary patterns cover the following:
- a byte change seen at frame 6 and again at frame 7,
- preambles missing before lock,
- a preamble arriving mid-block,
- an overrun past frame 191.

Together these separate correct counting from off-by-one errors in the window and the update point.

// File: rtl/cs_flag_pkg.sv
package cs_flag_pkg;

  localparam int unsigned B0_BITS = 8;

  typedef struct packed {
    logic pro;
    logic emph;
    logic nonaud;
  } cs_flags_t;

  // Decode the first status byte; the emphasis field moves with the format bit
  function automatic cs_flags_t decode_b0(input logic [B0_BITS-1:0] b);
    cs_flags_t f;
    f.pro    = b[0];
    f.nonaud = b[1];
    if (b[0]) f.emph = b[2] & b[3] & ~b[4];
    else      f.emph = b[3] & ~b[4] & ~b[5];
    return f;
  endfunction

endpackage

// File: rtl/cs_serial_out.sv
module cs_serial_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_stb,
  input  logic cs_in,
  input  logic ub_in,
  output logic cs_ser,
  output logic ub_ser
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_ser <= 1'b0;
      ub_ser <= 1'b0;
    end else if (sub_stb) begin
      cs_ser <= cs_in;
      ub_ser <= ub_in;
    end
  end
endmodule

// File: rtl/cs_frame_ctr.sv
module cs_frame_ctr #(
  parameter int unsigned BLK_FRAMES = 192,
  parameter int unsigned WIN_FRAMES = 32,
  parameter int unsigned FW         = $clog2(BLK_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          left_stb,
  input  logic          b_pre,
  output logic [FW-1:0] frame_idx,
  output logic          frame_vld,
  output logic          wrap_evt,
  output logic          blk_win,
  output logic          sync_err
);
  logic [FW-1:0] cnt_q;
  logic          synced_q;
  logic          at_end;

  assign at_end    = (cnt_q == FW'(BLK_FRAMES - 1));
  assign frame_vld = left_stb && (b_pre || synced_q);
  assign wrap_evt  = left_stb && !b_pre && synced_q && at_end;
  assign frame_idx = (b_pre || at_end || !synced_q) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
      blk_win  <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      if (frame_vld) begin
        cnt_q    <= frame_idx;
        synced_q <= 1'b1;
        blk_win  <= (frame_idx < FW'(WIN_FRAMES));
      end
      if (wrap_evt) sync_err <= 1'b1;
    end
  end
endmodule

// File: rtl/cs_byte0_dec.sv
module cs_byte0_dec
  import cs_flag_pkg::*;
#(
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_vld,
  input  logic [FW-1:0] frame_idx,
  input  logic          cs_bit,
  output logic          b0_done,
  output cs_flags_t     flags
);
  logic [B0_BITS-2:0] low_bits;

  assign b0_done = frame_vld && (frame_idx == FW'(B0_BITS - 1));

  for (genvar gi = 0; gi < B0_BITS - 1; gi++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   low_bits[gi] <= 1'b0;
      else if (frame_vld && frame_idx == FW'(gi))   low_bits[gi] <= cs_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (b0_done) flags <= decode_b0({cs_bit, low_bits});
  end
endmodule

// File: rtl/cs_flag_extract.sv
module cs_flag_extract
  import cs_flag_pkg::*;
#(
  parameter int unsigned BLK_FRAMES = 192,
  parameter int unsigned WIN_FRAMES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_stb,
  input  logic sub_right,
  input  logic b_pre,
  input  logic cs_in,
  input  logic ub_in,
  output logic cs_ser,
  output logic ub_ser,
  output logic blk_win,
  output logic pro_mode,
  output logic emph_flag,
  output logic nonaudio_flag,
  output logic sync_err
);
  localparam int unsigned FW = $clog2(BLK_FRAMES);

  logic          left_stb;
  logic          frame_vld;
  logic          wrap_evt;
  logic          b0_done;
  logic [FW-1:0] frame_idx;
  cs_flags_t     flags;

  assign left_stb = sub_stb && !sub_right;

  cs_serial_out u_ser (
    .clk(clk), .rst_n(rst_n), .sub_stb(sub_stb),
    .cs_in(cs_in), .ub_in(ub_in), .cs_ser(cs_ser), .ub_ser(ub_ser)
  );

  cs_frame_ctr #(.BLK_FRAMES(BLK_FRAMES), .WIN_FRAMES(WIN_FRAMES), .FW(FW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .left_stb(left_stb), .b_pre(b_pre),
    .frame_idx(frame_idx), .frame_vld(frame_vld), .wrap_evt(wrap_evt),
    .blk_win(blk_win), .sync_err(sync_err)
  );

  cs_byte0_dec #(.FW(FW)) u_dec (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_idx(frame_idx),
    .cs_bit(cs_in), .b0_done(b0_done), .flags(flags)
  );

  assign pro_mode      = flags.pro;
  assign emph_flag     = flags.emph;
  assign nonaudio_flag = flags.nonaud;
endmodule

// File: rtl/cs_flag_extract_chk.sv
module cs_flag_extract_chk #(
  parameter int unsigned FW = 8,
  parameter int unsigned WIN_FRAMES = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sub_stb,
  input logic          cs_in,
  input logic          ub_in,
  input logic          cs_ser,
  input logic          ub_ser,
  input logic          blk_win,
  input logic          pro_mode,
  input logic          emph_flag,
  input logic          nonaudio_flag,
  input logic          sync_err,
  input logic          left_stb,
  input logic          frame_vld,
  input logic          b0_done,
  input logic [FW-1:0] frame_idx
);
  // R1
  ser_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb |=> (cs_ser == $past(cs_in)) && (ub_ser == $past(ub_in)));
  // R1
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_stb |=> $stable(cs_ser) && $stable(ub_ser));
  // R2
  win_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !left_stb |=> $stable(blk_win));
  // R3
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && frame_idx == '0) |=> blk_win);
  // R3
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && frame_idx == FW'(WIN_FRAMES)) |=> !blk_win);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b0_done |=> $stable({pro_mode, emph_flag, nonaudio_flag}));
  // R10
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);
  // R11
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |-> !(cs_ser | ub_ser | blk_win | pro_mode | emph_flag | nonaudio_flag | sync_err));
endmodule

bind cs_flag_extract cs_flag_extract_chk #(.FW(FW), .WIN_FRAMES(WIN_FRAMES)) u_chk (.*);

// File: tb/cs_flag_extract_bench.sv
module cs_flag_extract_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_stb = 1'b0, sub_right = 1'b0, b_pre = 1'b0, cs_in = 1'b0, ub_in = 1'b0;
  logic cs_ser, ub_ser, blk_win, pro_mode, emph_flag, nonaudio_flag, sync_err;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cs_flag_extract u_cs_flag_extract (.*);

  // byte 0 patterns and expected {pro, emph, nonaudio}
  localparam logic [7:0] VEC_B0 [8] = '{8'h00, 8'h08, 8'h02, 8'h0C, 8'h18, 8'h09, 8'h1D, 8'h0D};
  localparam logic [2:0] VEC_EX [8] = '{3'b000, 3'b010, 3'b001, 3'b010, 3'b000, 3'b100, 3'b100, 3'b110};

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] flags_now();
    return {5'b0, pro_mode, emph_flag, nonaudio_flag};
  endfunction

  task automatic sub(bit right, bit b, bit cs, bit ub);
    @(negedge clk);
    sub_stb = 1'b1; sub_right = right; b_pre = b; cs_in = cs; ub_in = ub;
    @(negedge clk);
    sub_stb = 1'b0; b_pre = 1'b0;
    chk("R1 status stream", {7'b0, cs_ser}, {7'b0, cs});
    chk("R1 user stream", {7'b0, ub_ser}, {7'b0, ub});
  endtask

  task automatic frame(int f, logic [7:0] lb, bit b, bit locked);
    bit lcs, rcs;
    lcs = (f < 8) ? lb[f] : bit'(f % 5 == 1);
    rcs = (f < 8) ? ~lb[f] : bit'(f % 3 == 0);
    sub(1'b0, b, lcs, f[1]);
    chk("R3 window", {7'b0, blk_win}, {7'b0, locked && (f < 32)});
    sub(1'b1, 1'b0, rcs, ~f[0]);
  endtask

  task automatic block(logic [7:0] lb, bit first_b, int n, bit locked);
    for (int f = 0; f < n; f++) frame(f, lb, first_b && f == 0, locked);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 outputs in reset", {1'b0, cs_ser, ub_ser, blk_win, pro_mode, emph_flag, nonaudio_flag, sync_err}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 frames before first preamble are ignored
    block(8'h0D, 1'b0, 12, 1'b0);
    chk("R2 flags before lock", flags_now(), 8'h00);

    // R5/R6/R7/R8 table of byte-0 patterns, right channel carries the complement (R4)
    for (int i = 0; i < 8; i++) begin
      block(VEC_B0[i], 1'b1, 192, 1'b1);
      chk("R5/R6/R7/R8 decoded flags", flags_now(), {5'b0, VEC_EX[i]});
      chk("R10 no error while aligned", {7'b0, sync_err}, 8'h00);
    end

    // R9 flags hold until frame 7, then R4/R8 new byte from left only
    block(8'h02, 1'b1, 7, 1'b1);
    chk("R9 hold through frame 6", flags_now(), 8'h06);
    frame(7, 8'h02, 1'b0, 1'b1);
    chk("R4 update at frame 7 left only", flags_now(), 8'h01);

    // R2 mid-block preamble restarts the count
    for (int f = 8; f < 50; f++) frame(f, 8'h02, 1'b0, 1'b1);
    block(8'h08, 1'b1, 192, 1'b1);
    chk("R2 resync flags", flags_now(), 8'h02);
    chk("R2 resync no error", {7'b0, sync_err}, 8'h00);

    // R10 overrun past frame 191 wraps and sets the sticky error
    block(8'h03, 1'b0, 40, 1'b1);
    chk("R10 wrap sets error", {7'b0, sync_err}, 8'h01);
    chk("R10 wrapped frame acts as frame 0", flags_now(), 8'h05);
    block(8'h00, 1'b1, 192, 1'b1);
    chk("R10 error is sticky", {7'b0, sync_err}, 8'h01);
    chk("R7 consumer plain", flags_now(), 8'h00);

    // R11 reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 outputs after reset", {1'b0, cs_ser, ub_ser, blk_win, pro_mode, emph_flag, nonaudio_flag, sync_err}, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule